// File: doc/BRIEF.md
# Multi-Pair Conversion Sequencer

This block sits between a sigma-delta converter's decimation datapath and the logic that consumes its results. It decides which differential input pair is converted, requests each conversion, and waits for the datapath to report a finished sample. It then holds that sample in a result register and manages the handshake flags that tell a reader when data is fresh and when data was lost.

A single start request covers one pair or several. If the three-bit enable mask is zero, the block converts the one pair named by the mux-select input. If the mask has any bit set, the block visits every enabled pair from the lowest index upward and skips disabled pairs without spending a conversion slot on them. Each result that is stored carries the index of the pair it came from. A one-cycle trigger strobe marks each stored result, so a DMA engine or an event consumer can act on it.

A reader clears the ready flag with a read strobe. The overrun flag records that a result was replaced before anyone read it, and only an explicit clear strobe removes it.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy_o, conv_req_o, res_ready_o, overrun_o and res_trig_o are all 0.
- R2: A start with seq_mask_i = 0 converts only pair mux_sel_i. On the next cycle conv_req_o is 1 and chan_sel_o equals mux_sel_i, and exactly one result is stored for that start.
- R3: A start with a non-zero seq_mask_i (bit k enables pair k) converts each enabled pair once, in ascending index order, and skips disabled pairs. The request for the next enabled pair appears on the cycle after the previous result is stored.
- R4: A start with seq_mask_i = 0 and mux_sel_i of 3 or more (no such pair) is ignored: busy_o and conv_req_o stay 0.
- R5: busy_o is 1 from the cycle after a start is accepted until the edge that stores the last result of that start, where it falls. conv_req_o is a one-cycle pulse and is asserted only while busy_o is 1.
- R6: A start that arrives while busy_o is 1 is ignored. The running sequence keeps its channel order, and no further conversion follows it.
- R7: When conv_done_i is 1 while busy, the next cycle shows res_data_o equal to the conv_data_i given with it, and res_chan_o equal to the pair being converted.
- R8: Storing a result sets res_ready_o. A read strobe rd_i clears res_ready_o at the next edge, unless a new result is stored at that same edge, in which case res_ready_o stays 1.
- R9: overrun_o is set when a result is stored while res_ready_o is 1 and rd_i is 0. A read strobe in the same cycle as the new result prevents the set. Only ovr_clr_i clears overrun_o, and a set in the same cycle takes precedence over the clear.
- R10: res_trig_o pulses for exactly one cycle, on the cycle after each stored result.
- R11: conv_done_i is ignored while busy_o is 0: the result register and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-conversion request |
| seq_mask_i | input | 3 | Per-pair sequence enable, bit k for pair k |
| mux_sel_i | input | 2 | Pair used when seq_mask_i is zero |
| conv_done_i | input | 1 | Datapath reports a finished sample |
| conv_data_i | input | 24 | Signed sample from the datapath |
| rd_i | input | 1 | Result read strobe |
| ovr_clr_i | input | 1 | Overrun clear strobe |
| conv_req_o | output | 1 | One-cycle conversion request to the datapath |
| chan_sel_o | output | 2 | Pair selected for the current conversion |
| busy_o | output | 1 | A sequence is in progress |
| res_data_o | output | 24 | Stored result |
| res_chan_o | output | 2 | Pair index of the stored result |
| res_ready_o | output | 1 | Unread result present |
| overrun_o | output | 1 | An unread result was overwritten |
| res_trig_o | output | 1 | One-cycle strobe per stored result, for DMA or event use |

## Verification
Two events can land on the same edge: a new result arriving from the datapath and the reader's strobe consuming the previous one. The bench makes them coincide by asserting rd_i in the cycle that carries conv_done_i, partway through a two-pair sequence. It then expects res_ready_o to stay set, overrun_o to stay clear, and the second pair's data to be shown. A related case asserts ovr_clr_i together with an overwriting result and expects overrun_o to end up set.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } seq_state_e;
endpackage

// File: rtl/convseq_lowbit.sv
// Lowest-set-bit encoder: gives the smallest enabled pair index.
module convseq_lowbit #(
   parameter int N = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   always_comb begin
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (mask_i[k]) idx_o = IW'(k);
      end
   end
   assign any_o = |mask_i;
endmodule

// File: rtl/convseq_ctrl.sv
// Sequencing FSM: builds the work mask, issues requests, walks the pairs.
module convseq_ctrl
   import convseq_pkg::*;
#(
   parameter int N = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [N-1:0]  seq_mask_i,
   input  logic [IW-1:0] mux_sel_i,
   input  logic          conv_done_i,
   output logic          conv_req_o,
   output logic [IW-1:0] chan_sel_o,
   output logic          busy_o,
   output logic          load_o
);
   localparam logic [IW:0] NPAIR = (IW + 1)'(N);

   seq_state_e    st_q;
   logic [N-1:0]  pend_q;
   logic [IW-1:0] chan_q;
   logic          req_q;

   logic [N-1:0]  fb_mask, cur_oh, eff_mask, rem_mask;
   logic [IW-1:0] first_idx, next_idx;
   logic          first_any, next_any;

   // Fallback one-hot from the mux field, and one-hot of the current pair.
   for (genvar g = 0; g < N; g++) begin : g_onehot
      assign fb_mask[g] = (mux_sel_i == IW'(g));
      assign cur_oh[g]  = (chan_q == IW'(g));
   end

   assign eff_mask = (|seq_mask_i) ? seq_mask_i : fb_mask;
   assign rem_mask = pend_q & ~cur_oh;

   convseq_lowbit #(.N(N)) u_first (
      .mask_i (eff_mask),
      .idx_o  (first_idx),
      .any_o  (first_any)
   );

   convseq_lowbit #(.N(N)) u_next (
      .mask_i (rem_mask),
      .idx_o  (next_idx),
      .any_o  (next_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         pend_q <= '0;
         chan_q <= '0;
         req_q  <= 1'b0;
      end else begin
         req_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (start_i && first_any) begin
                  pend_q <= eff_mask;
                  chan_q <= first_idx;
                  req_q  <= 1'b1;
                  st_q   <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (conv_done_i) begin
                  pend_q <= rem_mask;
                  if (next_any) begin
                     chan_q <= next_idx;
                     req_q  <= 1'b1;
                  end else begin
                     st_q <= SQ_IDLE;
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign conv_req_o = req_q;
   assign chan_sel_o = chan_q;
   assign busy_o     = (st_q == SQ_WAIT);
   assign load_o     = (st_q == SQ_WAIT) && conv_done_i;

   // R3: a follow-on request inside a sequence always moves to a higher pair
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && $past(st_q) == SQ_WAIT) |-> (chan_q > $past(chan_q)));

   // R5: requests are only issued while busy
   a_r5_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |-> busy_o);

   // R6: while waiting, a start request does not disturb the work set
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_WAIT && !conv_done_i && start_i) |=> ($stable(pend_q) && $stable(chan_q)));

   // R4: a nonexistent mux pair with an empty mask never starts a sequence
   a_r4_bad_mux: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE && start_i && !(|seq_mask_i) && ({1'b0, mux_sel_i} >= NPAIR))
      |=> !busy_o);
endmodule

// File: rtl/convseq_result.sv
// Result register with ready, overrun and trigger flags.
module convseq_result #(
   parameter int RES_W = 24,
   parameter int IW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [RES_W-1:0] data_i,
   input  logic [IW-1:0]    chan_i,
   input  logic             rd_i,
   input  logic             ovr_clr_i,
   output logic [RES_W-1:0] data_o,
   output logic [IW-1:0]    chan_o,
   output logic             ready_o,
   output logic             overrun_o,
   output logic             trig_o
);
   logic [RES_W-1:0] data_q;
   logic [IW-1:0]    chan_q;
   logic             ready_q, ovr_q, trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         chan_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
         trig_q  <= 1'b0;
      end else begin
         trig_q <= load_i;
         if (load_i) begin
            data_q <= data_i;
            chan_q <= chan_i;
         end
         if (load_i)    ready_q <= 1'b1;
         else if (rd_i) ready_q <= 1'b0;
         if (load_i && ready_q && !rd_i) ovr_q <= 1'b1;
         else if (ovr_clr_i)             ovr_q <= 1'b0;
      end
   end

   assign data_o    = data_q;
   assign chan_o    = chan_q;
   assign ready_o   = ready_q;
   assign overrun_o = ovr_q;
   assign trig_o    = trig_q;

   // R7: stored data follows the sample given with the done strobe
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (data_o == $past(data_i)));

   // R8: a read with no new result empties the register
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !load_i) |=> !ready_o);

   // R9: overrun persists until an explicit clear
   a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !ovr_clr_i) |=> overrun_o);

   // R9: overwrite of an unread result sets overrun
   a_r9_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && ready_o && !rd_i) |=> overrun_o);

   // R10: each trigger coincides with a fresh result
   a_r10_trig_ready: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> ready_o);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int NUM_PAIRS = 3,
   parameter int RES_W     = 24,
   localparam int IW       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [NUM_PAIRS-1:0] seq_mask_i,
   input  logic [IW-1:0]        mux_sel_i,
   input  logic                 conv_done_i,
   input  logic [RES_W-1:0]     conv_data_i,
   input  logic                 rd_i,
   input  logic                 ovr_clr_i,
   output logic                 conv_req_o,
   output logic [IW-1:0]        chan_sel_o,
   output logic                 busy_o,
   output logic [RES_W-1:0]     res_data_o,
   output logic [IW-1:0]        res_chan_o,
   output logic                 res_ready_o,
   output logic                 overrun_o,
   output logic                 res_trig_o
);
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("conv_sequencer: NUM_PAIRS must be at least 1");
   end
   if (RES_W < 1) begin : g_bad_width
      $error("conv_sequencer: RES_W must be at least 1");
   end

   logic load;

   convseq_ctrl #(.N(NUM_PAIRS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .seq_mask_i  (seq_mask_i),
      .mux_sel_i   (mux_sel_i),
      .conv_done_i (conv_done_i),
      .conv_req_o  (conv_req_o),
      .chan_sel_o  (chan_sel_o),
      .busy_o      (busy_o),
      .load_o      (load)
   );

   convseq_result #(.RES_W(RES_W), .IW(IW)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .data_i    (conv_data_i),
      .chan_i    (chan_sel_o),
      .rd_i      (rd_i),
      .ovr_clr_i (ovr_clr_i),
      .data_o    (res_data_o),
      .chan_o    (res_chan_o),
      .ready_o   (res_ready_o),
      .overrun_o (overrun_o),
      .trig_o    (res_trig_o)
   );

   // R11: a done strobe outside a sequence stores nothing
   a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && conv_done_i && !rd_i) |=> $stable(res_data_o));
endmodule

// File: tb/sim_conv_sequencer.sv
`timescale 1ns/1ps
module sim_conv_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  seq_mask_i = '0;
   logic [1:0]  mux_sel_i = '0;
   logic        conv_done_i = 1'b0;
   logic [23:0] conv_data_i = '0;
   logic        rd_i = 1'b0;
   logic        ovr_clr_i = 1'b0;
   logic        conv_req_o, busy_o, res_ready_o, overrun_o, res_trig_o;
   logic [1:0]  chan_sel_o, res_chan_o;
   logic [23:0] res_data_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   conv_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_mask_i(seq_mask_i),
      .mux_sel_i(mux_sel_i), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
      .rd_i(rd_i), .ovr_clr_i(ovr_clr_i), .conv_req_o(conv_req_o),
      .chan_sel_o(chan_sel_o), .busy_o(busy_o), .res_data_o(res_data_o),
      .res_chan_o(res_chan_o), .res_ready_o(res_ready_o), .overrun_o(overrun_o),
      .res_trig_o(res_trig_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_start(input logic [2:0] mask, input logic [1:0] mux);
      @(negedge clk);
      start_i = 1'b1; seq_mask_i = mask; mux_sel_i = mux;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic respond(input logic [23:0] d, input logic rd, input logic clr);
      @(negedge clk);
      conv_done_i = 1'b1; conv_data_i = d; rd_i = rd; ovr_clr_i = clr;
      @(negedge clk);
      conv_done_i = 1'b0; rd_i = 1'b0; ovr_clr_i = 1'b0;
   endtask

   task automatic read_pulse();
      @(negedge clk); rd_i = 1'b1;
      @(negedge clk); rd_i = 1'b0;
   endtask

   task automatic clr_pulse();
      @(negedge clk); ovr_clr_i = 1'b1;
      @(negedge clk); ovr_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", busy_o, 0);
      chk("R1 req", conv_req_o, 0);
      chk("R1 ready", res_ready_o, 0);
      chk("R1 overrun", overrun_o, 0);
      chk("R1 trig", res_trig_o, 0);
   endtask

   task automatic t_single();
      do_start(3'b000, 2'd2);
      chk("R2 req", conv_req_o, 1);
      chk("R2 chan", chan_sel_o, 2);
      chk("R5 busy", busy_o, 1);
      respond(24'h123456, 0, 0);
      chk("R7 data", res_data_o, 24'h123456);
      chk("R7 chan", res_chan_o, 2);
      chk("R8 ready", res_ready_o, 1);
      chk("R10 trig", res_trig_o, 1);
      chk("R5 busy falls", busy_o, 0);
      chk("R2 one result", conv_req_o, 0);
      read_pulse();
      chk("R8 read clears", res_ready_o, 0);
      chk("R10 trig one cycle", res_trig_o, 0);
      chk("R9 no overrun", overrun_o, 0);
   endtask

   task automatic t_sequence();
      do_start(3'b101, 2'd1);
      chk("R3 first chan", chan_sel_o, 0);
      respond(24'hA00001, 0, 0);
      chk("R3 res chan0", res_chan_o, 0);
      chk("R3 next req", conv_req_o, 1);
      chk("R3 skip to 2", chan_sel_o, 2);
      chk("R5 still busy", busy_o, 1);
      read_pulse();
      respond(24'hB00002, 0, 0);
      chk("R3 res chan2", res_chan_o, 2);
      chk("R7 data2", res_data_o, 24'hB00002);
      chk("R3 done", busy_o, 0);
      chk("R9 clean", overrun_o, 0);
      read_pulse();
   endtask

   task automatic t_bad_mux();
      do_start(3'b000, 2'd3);
      chk("R4 req", conv_req_o, 0);
      chk("R4 busy", busy_o, 0);
      @(negedge clk);
      chk("R4 busy later", busy_o, 0);
   endtask

   task automatic t_overrun();
      do_start(3'b011, 2'd0);
      respond(24'h000111, 0, 0);
      chk("R9 none yet", overrun_o, 0);
      respond(24'h000222, 0, 0);
      chk("R9 set", overrun_o, 1);
      chk("R7 newest", res_data_o, 24'h000222);
      chk("R7 newest chan", res_chan_o, 1);
      read_pulse();
      chk("R8 cleared", res_ready_o, 0);
      chk("R9 read keeps", overrun_o, 1);
      clr_pulse();
      chk("R9 clr", overrun_o, 0);
   endtask

   task automatic t_same_cycle();
      do_start(3'b110, 2'd0);
      chk("R3 chan1 first", chan_sel_o, 1);
      respond(24'h0C0C01, 0, 0);
      respond(24'h0C0C02, 1, 0);
      chk("R8 read+new ready", res_ready_o, 1);
      chk("R9 read+new no ovr", overrun_o, 0);
      chk("R7 read+new data", res_data_o, 24'h0C0C02);
      chk("R7 read+new chan", res_chan_o, 2);
      do_start(3'b000, 2'd0);
      respond(24'h0D0D03, 0, 1);
      chk("R9 set beats clr", overrun_o, 1);
      clr_pulse();
      chk("R9 cleared", overrun_o, 0);
      read_pulse();
   endtask

   task automatic t_start_busy();
      do_start(3'b011, 2'd0);
      @(negedge clk);
      start_i = 1'b1; seq_mask_i = 3'b100;
      @(negedge clk);
      start_i = 1'b0;
      chk("R6 chan held", chan_sel_o, 0);
      chk("R6 busy", busy_o, 1);
      respond(24'h0E0001, 0, 0);
      chk("R6 next chan", chan_sel_o, 1);
      read_pulse();
      respond(24'h0E0002, 0, 0);
      chk("R6 ends", busy_o, 0);
      repeat (3) @(negedge clk);
      chk("R6 no extra req", conv_req_o, 0);
      chk("R6 idle", busy_o, 0);
      read_pulse();
   endtask

   task automatic t_idle_done();
      respond(24'hABCDEF, 0, 0);
      chk("R11 ready", res_ready_o, 0);
      chk("R11 data", res_data_o, 24'h0E0002);
      chk("R11 trig", res_trig_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_sequence();
      t_bad_mux();
      t_overrun();
      t_same_cycle();
      t_start_busy();
      t_idle_done();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule